// File: doc/BRIEF.md
# Confidence-Ordered Prefetch Issue Controller

This block sits between the prefetch generators and the memory hierarchy. Each generator offers candidate prefetches. A candidate carries an address, a 4-bit confidence and the id of the core that produced it. The controller holds up to sixteen pending candidates. Whenever the downstream port is ready, it sends out the most confident one, whatever its arrival order or source.

Two throttles decide which candidates may enter the buffer.

- **Miss-rate threshold.** The controller counts cache misses over fixed windows of accesses. At the end of each window it turns the miss count into a confidence threshold by a right shift, saturated to the largest confidence. Candidates below the threshold are discarded, so a cache that is missing often accepts only confident prefetches.
- **Fairness throttle.** The controller counts useless-prefetch reports per core over fixed cycle intervals. At the end of each interval it shuts off prefetching for the next interval on the core with the worst record.

Top module: `pf_issue_arbiter`

## Requirements
- R1: After reset, `out_valid` is 0, `core_en` is all ones, and the confidence threshold is 0, so a candidate with confidence 0 is accepted.
- R2: The issued entry has the highest confidence among the buffered entries. Among entries of equal confidence, the one that entered first is issued first.
- R3: Exactly one entry leaves the buffer in each cycle in which `out_valid` and `out_ready` are both high. Otherwise every buffered entry stays, and `out_valid` remains high.
- R4: When all ENTRIES slots are occupied and no entry leaves in that cycle, an admitted candidate is handled as follows.
  - It replaces the entry with the lowest confidence, taking the most recently arrived entry among equal lowest confidences, only if its confidence is strictly greater.
  - Otherwise the candidate is dropped.
- R5: Thresholds are updated per window of WIN_ACC access pulses.
  - At the cycle of the last access of each window, the threshold becomes min(2^CONF_W-1, misses >> MISS_SHIFT), where misses counts every miss pulse in the window, including that cycle's.
  - A candidate whose confidence is below the current threshold is discarded.
- R6: Each `useless_evt` pulse adds one to the counter of the core named by `useless_core`. Counters are kept separately per core and saturate.
- R7: Every FAIR_PERIOD cycles after reset, the block evaluates the counters, including that cycle's pulse.
  - The core with the largest count gets a 0 in `core_en` for the next interval. Ties go to the lowest core id.
  - If every count is zero, all cores are enabled.
  - All counters then clear.
- R8: A candidate whose core has a 0 in `core_en` is discarded.
- R9: An accepted candidate can appear on the output in the cycle after it is offered, not in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cand_valid | input | 1 | Candidate prefetch offered this cycle |
| cand_addr | input | ADDR_W | Candidate address |
| cand_conf | input | CONF_W | Candidate confidence |
| cand_core | input | $clog2(CORES) | Core that produced the candidate |
| acc_evt | input | 1 | One cache access observed |
| miss_evt | input | 1 | One cache miss observed |
| useless_evt | input | 1 | One useless prefetch reported |
| useless_core | input | $clog2(CORES) | Core the useless prefetch belonged to |
| out_ready | input | 1 | Downstream accepts a request this cycle |
| out_valid | output | 1 | A request is presented |
| out_addr | output | ADDR_W | Issued address |
| out_conf | output | CONF_W | Issued confidence |
| out_core | output | $clog2(CORES) | Issued core id |
| core_en | output | CORES | Per-core prefetch enable |

## Verification
The assertions check the following on every cycle:
- a presented request never vanishes while the port is stalled;
- at most one core is ever switched off;
- `core_en` changes only on an interval boundary;
- no candidate is admitted below the threshold or from a disabled core.

The following can only be shown by the bench's scenarios:
- the issue order under mixed confidences;
- the victim chosen when the buffer is full;
- the exact threshold produced for each miss count in a window;
- which core is picked under tied useless counts.

// File: rtl/pfa_pkg.sv
package pfa_pkg;
    localparam int PFA_ADDR_W  = 32;
    localparam int PFA_CONF_W  = 4;
    localparam int PFA_CORES   = 4;
    localparam int PFA_ENTRIES = 16;
endpackage

// File: rtl/pfa_conf_buffer.sv
module pfa_conf_buffer #(
    parameter int ENTRIES = 16,
    parameter int ADDR_W  = 32,
    parameter int CONF_W  = 4,
    parameter int CORE_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cand_valid,
    input  logic [ADDR_W-1:0] cand_addr,
    input  logic [CONF_W-1:0] cand_conf,
    input  logic [CORE_W-1:0] cand_core,
    input  logic              cand_ok,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic [CONF_W-1:0] out_conf,
    output logic [CORE_W-1:0] out_core,
    output logic              take
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int CNT_W = $clog2(ENTRIES + 1);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CONF_W-1:0] conf;
        logic [CORE_W-1:0] core;
    } ent_t;

    // slots [0, cnt) hold live entries, kept in arrival order
    typedef struct packed {
        ent_t [ENTRIES-1:0] ent;
        logic [CNT_W-1:0]   cnt;
    } st_t;

    st_t st_q, st_d;
    logic [IDX_W-1:0] best, vic;
    logic fire, full, replace;

    always_comb begin
        logic [CNT_W-1:0] n;
        st_d = st_q;
        best = '0;
        vic  = '0;
        for (int i = 1; i < ENTRIES; i++) begin
            if (CNT_W'(i) < st_q.cnt && st_q.ent[i].conf > st_q.ent[best].conf)
                best = IDX_W'(i);
        end
        for (int i = 1; i < ENTRIES; i++) begin
            if (CNT_W'(i) < st_q.cnt && st_q.ent[i].conf <= st_q.ent[vic].conf)
                vic = IDX_W'(i);
        end
        out_valid = (st_q.cnt != '0);
        fire      = out_valid && out_ready;
        full      = (st_q.cnt == CNT_W'(ENTRIES));
        take      = cand_valid && cand_ok &&
                    (!full || fire || (cand_conf > st_q.ent[vic].conf));
        replace   = take && full && !fire;
        n = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (CNT_W'(i) < st_q.cnt &&
                !(fire && IDX_W'(i) == best) &&
                !(replace && IDX_W'(i) == vic)) begin
                st_d.ent[n[IDX_W-1:0]] = st_q.ent[i];
                n = n + 1'b1;
            end
        end
        if (take) begin
            st_d.ent[n[IDX_W-1:0]] = '{addr: cand_addr, conf: cand_conf, core: cand_core};
            n = n + 1'b1;
        end
        st_d.cnt = n;
    end

    assign out_addr = st_q.ent[best].addr;
    assign out_conf = st_q.ent[best].conf;
    assign out_core = st_q.ent[best].core;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pfa_miss_threshold.sv
module pfa_miss_threshold #(
    parameter int WIN_ACC    = 1024,
    parameter int MISS_SHIFT = 6,
    parameter int CONF_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_evt,
    input  logic              miss_evt,
    output logic [CONF_W-1:0] thr
);
    localparam int AW      = $clog2(WIN_ACC);
    localparam int MW      = ($clog2(WIN_ACC) + 2 > CONF_W) ? $clog2(WIN_ACC) + 2 : CONF_W;
    localparam int THR_MAX = (1 << CONF_W) - 1;

    typedef struct packed {
        logic [AW-1:0]     acc;
        logic [MW-1:0]     miss;
        logic [CONF_W-1:0] thr;
    } st_t;

    st_t st_q, st_d;

    always_comb begin
        logic [MW-1:0] m;
        logic [MW-1:0] sh;
        st_d = st_q;
        m    = st_q.miss + MW'(miss_evt && (st_q.miss != '1));
        sh   = m >> MISS_SHIFT;
        st_d.miss = m;
        if (acc_evt) begin
            if (st_q.acc == AW'(WIN_ACC - 1)) begin
                st_d.acc  = '0;
                st_d.miss = '0;
                st_d.thr  = (int'(sh) > THR_MAX) ? CONF_W'(THR_MAX) : sh[CONF_W-1:0];
            end else begin
                st_d.acc = st_q.acc + 1'b1;
            end
        end
    end

    assign thr = st_q.thr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pfa_fair_throttle.sv
module pfa_fair_throttle #(
    parameter int CORES       = 4,
    parameter int FAIR_PERIOD = 4096,
    parameter int USE_W       = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     useless_evt,
    input  logic [$clog2(CORES)-1:0] useless_core,
    output logic [CORES-1:0]         core_en
);
    localparam int CORE_W = $clog2(CORES);
    localparam int PW     = $clog2(FAIR_PERIOD);

    typedef struct packed {
        logic [PW-1:0]                cyc;
        logic [CORES-1:0][USE_W-1:0]  cnt;
        logic [CORES-1:0]             en;
    } st_t;

    st_t st_q, st_d;

    always_comb begin
        logic [CORES-1:0][USE_W-1:0] c;
        logic [CORE_W-1:0]           worst;
        st_d  = st_q;
        worst = '0;
        for (int i = 0; i < CORES; i++) begin
            c[i] = st_q.cnt[i] + USE_W'(useless_evt && useless_core == CORE_W'(i) &&
                                        st_q.cnt[i] != '1);
        end
        for (int i = 1; i < CORES; i++) begin
            if (c[i] > c[worst]) worst = CORE_W'(i);
        end
        if (st_q.cyc == PW'(FAIR_PERIOD - 1)) begin
            st_d.cyc = '0;
            st_d.cnt = '0;
            st_d.en  = (c[worst] == '0) ? '1 : ~(CORES'(1) << worst);
        end else begin
            st_d.cyc = st_q.cyc + 1'b1;
            st_d.cnt = c;
        end
    end

    assign core_en = st_q.en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cyc: '0, cnt: '0, en: '1};
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pf_issue_arbiter.sv
module pf_issue_arbiter
    import pfa_pkg::*;
#(
    parameter int ENTRIES     = PFA_ENTRIES,
    parameter int ADDR_W      = PFA_ADDR_W,
    parameter int CONF_W      = PFA_CONF_W,
    parameter int CORES       = PFA_CORES,
    parameter int WIN_ACC     = 1024,
    parameter int MISS_SHIFT  = 6,
    parameter int FAIR_PERIOD = 4096,
    parameter int USE_W       = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cand_valid,
    input  logic [ADDR_W-1:0]        cand_addr,
    input  logic [CONF_W-1:0]        cand_conf,
    input  logic [$clog2(CORES)-1:0] cand_core,
    input  logic                     acc_evt,
    input  logic                     miss_evt,
    input  logic                     useless_evt,
    input  logic [$clog2(CORES)-1:0] useless_core,
    input  logic                     out_ready,
    output logic                     out_valid,
    output logic [ADDR_W-1:0]        out_addr,
    output logic [CONF_W-1:0]        out_conf,
    output logic [$clog2(CORES)-1:0] out_core,
    output logic [CORES-1:0]         core_en
);
    localparam int CORE_W = $clog2(CORES);

    logic [CONF_W-1:0] thr_lvl;
    logic              cand_ok;
    logic              cand_take;

    assign cand_ok = (cand_conf >= thr_lvl) && core_en[cand_core];

    pfa_miss_threshold #(
        .WIN_ACC(WIN_ACC), .MISS_SHIFT(MISS_SHIFT), .CONF_W(CONF_W)
    ) u_thr (
        .clk(clk), .rst_n(rst_n), .acc_evt(acc_evt), .miss_evt(miss_evt), .thr(thr_lvl)
    );

    pfa_fair_throttle #(
        .CORES(CORES), .FAIR_PERIOD(FAIR_PERIOD), .USE_W(USE_W)
    ) u_fair (
        .clk(clk), .rst_n(rst_n), .useless_evt(useless_evt),
        .useless_core(useless_core), .core_en(core_en)
    );

    pfa_conf_buffer #(
        .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .CONF_W(CONF_W), .CORE_W(CORE_W)
    ) u_buf (
        .clk(clk), .rst_n(rst_n),
        .cand_valid(cand_valid), .cand_addr(cand_addr), .cand_conf(cand_conf),
        .cand_core(cand_core), .cand_ok(cand_ok), .out_ready(out_ready),
        .out_valid(out_valid), .out_addr(out_addr), .out_conf(out_conf),
        .out_core(out_core), .take(cand_take)
    );
endmodule

// File: rtl/pfa_checker.sv
module pfa_checker #(
    parameter int CORES       = 4,
    parameter int FAIR_PERIOD = 4096,
    parameter int CONF_W      = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [CONF_W-1:0]        cand_conf,
    input logic [$clog2(CORES)-1:0] cand_core,
    input logic                     take,
    input logic [CONF_W-1:0]        thr,
    input logic [CORES-1:0]         core_en,
    input logic                     out_valid,
    input logic                     out_ready
);
    localparam int PW = $clog2(FAIR_PERIOD);
    logic [PW-1:0] pc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_q + 1'b1;
    end

    AST_HOLD_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid); // R3
    AST_ONE_CORE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~core_en) <= 1); // R7
    AST_EN_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(core_en) |-> pc_q == '0); // R7
    AST_ADMIT_ABOVE_THR: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> cand_conf >= thr); // R5
    AST_ADMIT_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> core_en[cand_core]); // R8
endmodule

bind pf_issue_arbiter pfa_checker #(
    .CORES(CORES), .FAIR_PERIOD(FAIR_PERIOD), .CONF_W(CONF_W)
) i_chk (
    .clk(clk), .rst_n(rst_n), .cand_conf(cand_conf), .cand_core(cand_core),
    .take(cand_take), .thr(thr_lvl), .core_en(core_en),
    .out_valid(out_valid), .out_ready(out_ready)
);

// File: tb/test_pf_issue_arbiter.sv
`timescale 1ns/1ps
module test_pf_issue_arbiter;
    localparam int PER = 64;
    localparam int WIN = 32;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        cand_valid = 0;
    logic [31:0] cand_addr = 0;
    logic [3:0]  cand_conf = 0;
    logic [1:0]  cand_core = 0;
    logic        acc_evt = 0, miss_evt = 0, useless_evt = 0;
    logic [1:0]  useless_core = 0;
    logic        out_ready = 0;
    logic        out_valid;
    logic [31:0] out_addr;
    logic [3:0]  out_conf;
    logic [1:0]  out_core;
    logic [3:0]  core_en;

    int checks = 0, errors = 0, cyc = 0;

    pf_issue_arbiter #(.WIN_ACC(WIN), .MISS_SHIFT(1), .FAIR_PERIOD(PER)) i_pf_issue_arbiter (
        .clk(clk), .rst_n(rst_n), .cand_valid(cand_valid), .cand_addr(cand_addr),
        .cand_conf(cand_conf), .cand_core(cand_core), .acc_evt(acc_evt),
        .miss_evt(miss_evt), .useless_evt(useless_evt), .useless_core(useless_core),
        .out_ready(out_ready), .out_valid(out_valid), .out_addr(out_addr),
        .out_conf(out_conf), .out_core(out_core), .core_en(core_en)
    );

    always #4 clk = ~clk;
    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic push(input int addr, input int conf, input int core);
        cand_valid = 1; cand_addr = addr; cand_conf = conf[3:0]; cand_core = core[1:0];
        @(negedge clk);
        cand_valid = 0;
    endtask

    task automatic pop1();
        out_ready = 1; @(negedge clk); out_ready = 0;
    endtask

    // buffer must be empty; offers one candidate and checks admission
    task automatic probe(input int conf, input int core, input bit exp_acc, input string req);
        push(500, conf, core);
        chk(out_valid == exp_acc, req, out_valid, exp_acc);
        if (out_valid) pop1();
    endtask

    task automatic window(input int nmiss);
        for (int k = 0; k < WIN; k++) begin
            acc_evt = 1; miss_evt = (k < nmiss);
            @(negedge clk);
        end
        acc_evt = 0; miss_evt = 0;
    endtask

    initial begin
        int confs[8];
        bit used[8];
        int cnt4[4];
        int pats[5][4];
        confs = '{3, 7, 7, 1, 9, 3, 7, 0};
        pats = '{'{0,3,3,1}, '{2,0,0,5}, '{0,0,0,0}, '{4,4,4,4}, '{1,0,2,0}};
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk(out_valid == 0, "R1 out_valid", out_valid, 0);
        chk(core_en == 4'hF, "R1 core_en", core_en, 15);
        probe(0, 0, 1, "R1 threshold zero");

        // R2/R9 ordering by confidence, oldest first on ties
        for (int k = 0; k < 8; k++) begin
            push(100 + k, confs[k], 0);
            if (k == 0) chk(out_valid && out_addr == 100, "R9 next-cycle visibility", out_addr, 100);
        end
        foreach (used[j]) used[j] = 0;
        out_ready = 1;
        for (int s = 0; s < 8; s++) begin
            int bj;
            bj = -1;
            for (int j = 0; j < 8; j++)
                if (!used[j] && (bj < 0 || confs[j] > confs[bj])) bj = j;
            used[bj] = 1;
            chk(out_valid && out_addr == 100 + bj, "R2 issue order", out_addr, 100 + bj);
            chk(out_conf == confs[bj], "R3 one per cycle conf", out_conf, confs[bj]);
            @(negedge clk);
        end
        out_ready = 0;
        chk(out_valid == 0, "R3 drained", out_valid, 0);

        // R4 full buffer replacement
        for (int k = 0; k < 16; k++) push(200 + k, 5, 1);
        push(300, 5, 1);
        push(301, 9, 1);
        push(302, 2, 1);
        chk(out_valid == 1, "R3 held while stalled", out_valid, 1);
        out_ready = 1;
        chk(out_addr == 301, "R4 replacement issued first", out_addr, 301);
        @(negedge clk);
        for (int k = 0; k < 15; k++) begin
            chk(out_valid && out_addr == 200 + k, "R4 survivors in order", out_addr, 200 + k);
            @(negedge clk);
        end
        out_ready = 0;
        chk(out_valid == 0, "R4 newest equal-lowest evicted, others dropped", out_valid, 0);

        // R5 threshold sweep over miss counts
        for (int nm = 0; nm <= WIN; nm += 3) begin
            int t;
            window(nm);
            t = nm >> 1;
            if (t > 15) t = 15;
            if (t > 0) probe(t - 1, 0, 0, "R5 below threshold dropped");
            probe(t, 0, 1, "R5 at threshold accepted");
        end
        window(WIN);
        probe(14, 0, 0, "R5 saturated threshold drops 14");
        probe(15, 0, 1, "R5 saturated threshold accepts 15");
        window(0);
        probe(0, 0, 1, "R5 threshold back to zero");

        // R6/R7/R8 fairness throttle
        for (int p = 0; p < 5; p++) begin
            int w, expen;
            while ((cyc % PER) != 2) @(negedge clk);
            for (int c = 0; c < 4; c++) begin
                cnt4[c] = pats[p][c];
                for (int r = 0; r < cnt4[c]; r++) begin
                    useless_evt = 1; useless_core = c[1:0];
                    @(negedge clk);
                end
            end
            useless_evt = 0;
            while ((cyc % PER) != 1) @(negedge clk);
            w = 0;
            for (int c = 1; c < 4; c++) if (cnt4[c] > cnt4[w]) w = c;
            expen = (cnt4[w] == 0) ? 15 : (15 & ~(1 << w));
            chk(core_en == expen, "R7 worst core disabled", core_en, expen);
            if (expen != 15) begin
                probe(5, w, 0, "R8 disabled core dropped");
                probe(5, (w + 1) % 4, 1, "R8 enabled core accepted");
            end
        end
        // counters cleared: quiet interval re-enables all (R6 per-core reset)
        while ((cyc % PER) != 1) @(negedge clk);
        chk(core_en == 4'hF, "R6 counters cleared", core_en, 15);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule